// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block holds a set of numbered hardware queues of descriptor addresses. Each queue is a singly linked list. The links live in an internal link memory, one entry per descriptor. For each queue the block keeps a head index, a tail index and an entry count. An agent sends requests through one valid/ready port. A push appends a descriptor address to the tail of the selected queue. A pop removes the head of that queue and returns its address.

Descriptors sit in memory regions, and each region is set up through a small configuration port. A region has an enable bit, a 16-byte-aligned base address, a start index into the link memory, a descriptor size and a descriptor count. The size and the count are both powers of two, and both are programmed as log2 values.

On a push, the block converts the address to a link index. On a pop, it converts the index back to an address. The same link memory can therefore serve regions of different descriptor sizes. A status port shows the count and the empty flag of any one queue.

Top module: `lldq_manager`

## Requirements
- R1: Each queue returns the addresses pushed onto it in first-in, first-out order. A pop of a descriptor pushed in the cycle just before returns that descriptor.
- R2: Region r is programmed with `cfg_size_log2` = s and `cfg_count_log2` = c, where s ≥ 5 (at least 32 bytes) and c ≥ 5 (at least 32 descriptors). Address A belongs to region r when A − base is below 2^c · 2^s and is a multiple of 2^s. Its link index is start + ((A − base) >> s). When regions overlap, the lowest-numbered enabled region wins.
- R3: A push whose address matches no enabled region is dropped. This covers an address below the base, an address past the region's end, an address not on a descriptor boundary, and an address in a disabled region. Such a push leaves every queue count unchanged and sets `push_err`. `push_err` stays high until reset.
- R4: A pop from an empty queue produces a response with `pop_addr` = 0 and leaves that queue's count at zero.
- R5: Every accepted pop produces exactly one `pop_valid` pulse, in the second cycle after the cycle in which the request was accepted. Pushes produce no pulse.
- R6: `stat_count` gives the number of entries in the queue selected by `stat_queue`. It rises by one on each accepted in-region push and falls by one on each pop of a non-empty queue. `stat_empty` is high exactly when that count is zero.
- R7: Queues are independent. Pushes and pops on one queue never change the contents or the count of another queue.
- R8: After reset, every queue is empty, `push_err` is low and `pop_valid` is low. `req_ready` is high from the first cycle after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the region selected by cfg_region |
| cfg_region | input | RW | Region number |
| cfg_enable | input | 1 | Region enable |
| cfg_base | input | AW | Region base address |
| cfg_start | input | IW | First link index of the region |
| cfg_size_log2 | input | 5 | log2 of the descriptor size in bytes |
| cfg_count_log2 | input | 5 | log2 of the descriptor count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_queue | input | QW | Queue number |
| req_addr | input | AW | Descriptor address to push |
| pop_valid | output | 1 | Pop response present |
| pop_addr | output | AW | Popped address, 0 when the queue was empty |
| push_err | output | 1 | Sticky flag for a dropped push |
| stat_queue | input | QW | Queue to report on |
| stat_count | output | IW+1 | Entry count of stat_queue |
| stat_empty | output | 1 | stat_queue holds no entries |

## Verification
The bench sends a pop in the cycle right after a push to the same queue. A design that reads the link memory before the write has landed returns a stale address there.

It pushes the last descriptor of a region, and it pushes descriptors from regions of different sizes onto one queue. A wrong shift or a wrong region bound shows up as a translated address that differs from what was pushed.

It also pushes addresses that are misaligned, that lie past a region's end, or that fall in a disabled region. Each must leave the counts unchanged and raise the sticky flag. A design that accepts any of them shows a count that grows.

Finally, it pops empty queues, which must return zero without disturbing the count. A response that arrives one cycle early or late is flagged against the expected cycle.

// File: rtl/lldq_manager.sv
module lldq_manager #(
  parameter int AW          = 32,
  parameter int NUM_Q       = 8,
  parameter int NUM_REGIONS = 4,
  parameter int LINK_DEPTH  = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [$clog2(NUM_REGIONS)-1:0] cfg_region,
  input  logic                           cfg_enable,
  input  logic [AW-1:0]                  cfg_base,
  input  logic [$clog2(LINK_DEPTH)-1:0]  cfg_start,
  input  logic [4:0]                     cfg_size_log2,
  input  logic [4:0]                     cfg_count_log2,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_pop,
  input  logic [$clog2(NUM_Q)-1:0]       req_queue,
  input  logic [AW-1:0]                  req_addr,
  output logic                           pop_valid,
  output logic [AW-1:0]                  pop_addr,
  output logic                           push_err,
  input  logic [$clog2(NUM_Q)-1:0]       stat_queue,
  output logic [$clog2(LINK_DEPTH):0]    stat_count,
  output logic                           stat_empty
);
  localparam int IW = $clog2(LINK_DEPTH);
  localparam int CW = IW + 1;

  logic          rg_en    [NUM_REGIONS];
  logic [AW-1:0] rg_base  [NUM_REGIONS];
  logic [IW-1:0] rg_start [NUM_REGIONS];
  logic [4:0]    rg_szl   [NUM_REGIONS];
  logic [4:0]    rg_cnl   [NUM_REGIONS];

  logic [IW-1:0] head [NUM_Q];
  logic [IW-1:0] tail [NUM_Q];
  logic [CW-1:0] cnt  [NUM_Q];
  logic [IW-1:0] link [LINK_DEPTH];

  logic          rdy, p1_v, p1_ok;
  logic [IW-1:0] p1_idx;
  logic          push_hit;
  logic [IW-1:0] push_idx;
  logic [AW-1:0] idx_addr;

  wire acc      = req_valid && req_ready;
  wire acc_push = acc && !req_pop;
  wire acc_pop  = acc && req_pop;
  wire q_has    = cnt[req_queue] != '0;

  assign req_ready  = rdy;
  assign stat_count = cnt[stat_queue];
  assign stat_empty = stat_count == '0;

  // address -> link index; lowest-numbered region wins, so scan downward
  always_comb begin
    logic [AW:0] off;
    push_hit = 1'b0;
    push_idx = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      off = {1'b0, req_addr} - {1'b0, rg_base[r]};
      if (rg_en[r] && !off[AW]
          && ((off[AW-1:0] >> rg_szl[r]) < (AW'(1) << rg_cnl[r]))
          && ((off[AW-1:0] & ((AW'(1) << rg_szl[r]) - AW'(1))) == '0)) begin
        push_hit = 1'b1;
        push_idx = rg_start[r] + IW'(off[AW-1:0] >> rg_szl[r]);
      end
    end
  end

  // link index -> address
  always_comb begin
    logic [IW:0] rel;
    idx_addr = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      rel = {1'b0, p1_idx} - {1'b0, rg_start[r]};
      if (rg_en[r] && !rel[IW] && (AW'(rel[IW-1:0]) < (AW'(1) << rg_cnl[r])))
        idx_addr = rg_base[r] + (AW'(rel[IW-1:0]) << rg_szl[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        rg_en[r] <= 1'b0; rg_base[r] <= '0; rg_start[r] <= '0;
        rg_szl[r] <= 5'd5; rg_cnl[r] <= 5'd5;
      end
    end else if (cfg_we) begin
      rg_en[cfg_region]    <= cfg_enable;
      rg_base[cfg_region]  <= cfg_base & ~AW'(15);
      rg_start[cfg_region] <= cfg_start;
      rg_szl[cfg_region]   <= (cfg_size_log2 < 5'd5) ? 5'd5 : cfg_size_log2;
      rg_cnl[cfg_region]   <= (cfg_count_log2 < 5'd5) ? 5'd5 : cfg_count_log2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NUM_Q; q++) begin
        head[q] <= '0; tail[q] <= '0; cnt[q] <= '0;
      end
      rdy <= 1'b0; push_err <= 1'b0;
      p1_v <= 1'b0; p1_ok <= 1'b0; p1_idx <= '0;
      pop_valid <= 1'b0; pop_addr <= '0;
    end else begin
      rdy <= 1'b1;
      if (acc_push && push_hit) begin
        if (!q_has) head[req_queue] <= push_idx;
        tail[req_queue] <= push_idx;
        cnt[req_queue]  <= cnt[req_queue] + CW'(1);
      end
      if (acc_pop && q_has) begin
        head[req_queue] <= link[head[req_queue]];
        cnt[req_queue]  <= cnt[req_queue] - CW'(1);
      end
      push_err  <= push_err | (acc_push && !push_hit);
      p1_v      <= acc_pop;
      p1_ok     <= acc_pop && q_has;
      p1_idx    <= head[req_queue];
      pop_valid <= p1_v;
      pop_addr  <= p1_ok ? idx_addr : '0;
    end
  end

  always_ff @(posedge clk)
    if (acc_push && push_hit && q_has) link[tail[req_queue]] <= push_idx;

  assert_pop_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pop |-> ##2 pop_valid);
  assert_empty_pop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pop && !q_has) |-> ##2 (pop_valid && pop_addr == '0));
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_err |=> push_err);
  assert_drop_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_push && !push_hit) |=> cnt[$past(req_queue)] == $past(cnt[req_queue]));
  assert_pop_decrements_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pop && q_has) |=> cnt[$past(req_queue)] == $past(cnt[req_queue]) - CW'(1));
  assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);
endmodule

// File: tb/test_lldq_manager.sv
module test_lldq_manager;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 0, cfg_enable = 0;
  logic [1:0]  cfg_region = 0;
  logic [31:0] cfg_base = 0;
  logic [7:0]  cfg_start = 0;
  logic [4:0]  cfg_size_log2 = 5, cfg_count_log2 = 5;
  logic        req_valid = 0, req_pop = 0;
  logic [2:0]  req_queue = 0, stat_queue = 0;
  logic [31:0] req_addr = 0;
  logic        req_ready, pop_valid, push_err, stat_empty;
  logic [31:0] pop_addr;
  logic [8:0]  stat_count;

  lldq_manager i_lldq_manager (.*);

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] exp_addr[$];
  int          exp_cyc[$];
  string       exp_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cfg(input int r, input bit en, input logic [31:0] base, input int start, input int szl, input int cnl);
    @(negedge clk);
    cfg_we = 1; cfg_region = 2'(r); cfg_enable = en; cfg_base = base;
    cfg_start = 8'(start); cfg_size_log2 = 5'(szl); cfg_count_log2 = 5'(cnl);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(input int q, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1; req_pop = 0; req_queue = 3'(q); req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pop(input int q, input logic [31:0] expv, input string tag);
    @(negedge clk);
    req_valid = 1; req_pop = 1; req_queue = 3'(q);
    exp_addr.push_back(expv); exp_cyc.push_back(cyc + 2); exp_tag.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic count_is(input int q, input int n, input string tag);
    @(negedge clk);
    stat_queue = 3'(q);
    #1;
    chk(stat_count == 9'(n) && stat_empty == (n == 0), tag, 32'(stat_count), 32'(n));
  endtask

  // monitor: compare each response with the scoreboard head
  always @(negedge clk) if (rst_n && pop_valid) begin
    if (exp_addr.size() == 0) chk(0, "R5 unexpected pop_valid", pop_addr, 0);
    else begin
      logic [31:0] e; int c; string t;
      e = exp_addr.pop_front(); c = exp_cyc.pop_front(); t = exp_tag.pop_front();
      chk(cyc == c, {t, " R5 latency"}, 32'(cyc), 32'(c));
      chk(pop_addr == e, t, pop_addr, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pop_valid == 0, "R8 pop_valid in reset", 32'(pop_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R8 ready", 32'(req_ready), 1);
    chk(push_err == 0, "R8 push_err", 32'(push_err), 0);
    for (int q = 0; q < 8; q++) count_is(q, 0, "R8 empty after reset");

    cfg(0, 1, 32'h1000_0000, 0, 5, 5);    // 32 B x 32, idx 0..31
    cfg(1, 1, 32'h2000_0000, 32, 7, 6);   // 128 B x 64, idx 32..95
    cfg(2, 1, 32'h3000_0000, 96, 6, 5);   // 64 B x 32, idx 96..127
    cfg(3, 0, 32'h4000_0000, 128, 5, 5);  // disabled

    // R1 R2: mixed regions on one queue, last entries of regions
    push(0, 32'h1000_0000);
    push(0, 32'h2000_1F80);
    push(0, 32'h1000_03E0);
    push(0, 32'h3000_0040);
    count_is(0, 4, "R6 count after four pushes");
    pop(0, 32'h1000_0000, "R1 fifo 1");
    pop(0, 32'h2000_1F80, "R2 last of 128B region");
    pop(0, 32'h1000_03E0, "R2 last of 32B region");
    pop(0, 32'h3000_0040, "R1 fifo 4");
    count_is(0, 0, "R6 empty after pops");

    // R7: interleaved queues
    push(1, 32'h2000_0080);
    push(2, 32'h1000_0020);
    push(1, 32'h2000_0100);
    push(2, 32'h3000_0000);
    count_is(1, 2, "R7 q1 count");
    count_is(3, 0, "R7 q3 untouched");
    pop(2, 32'h1000_0020, "R7 q2 head");
    count_is(1, 2, "R7 q1 count after q2 pop");
    pop(1, 32'h2000_0080, "R7 q1 head");
    pop(1, 32'h2000_0100, "R7 q1 second");
    pop(2, 32'h3000_0000, "R7 q2 second");

    // R1: pop right after push, back to back
    @(negedge clk);
    req_valid = 1; req_pop = 0; req_queue = 3'd4; req_addr = 32'h1000_0040;
    @(negedge clk);
    req_pop = 1;
    exp_addr.push_back(32'h1000_0040); exp_cyc.push_back(cyc + 2); exp_tag.push_back("R1 back to back");
    @(negedge clk);
    req_valid = 0;

    // R4: pops of empty queues
    pop(5, 32'h0, "R4 empty pop");
    pop(4, 32'h0, "R4 empty pop after drain");
    count_is(5, 0, "R4 count stays zero");

    repeat (4) @(negedge clk);
    chk(push_err == 0, "R3 no error for valid pushes", 32'(push_err), 0);

    // R3: dropped pushes
    push(6, 32'h1000_0010);   // misaligned for 32 B
    push(6, 32'h1000_0400);   // past region end
    push(6, 32'h0FFF_FFE0);   // below base
    push(6, 32'h4000_0000);   // disabled region
    count_is(6, 0, "R3 dropped pushes");
    chk(push_err == 1, "R3 push_err set", 32'(push_err), 1);
    push(6, 32'h2000_0000);
    count_is(6, 1, "R6 valid push after error");
    chk(push_err == 1, "R3 push_err sticky", 32'(push_err), 1);
    pop(6, 32'h2000_0000, "R1 after errors");

    repeat (5) @(negedge clk);
    chk(exp_addr.size() == 0, "R5 missing responses", 32'(exp_addr.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule